// File: doc/BRIEF.md
# Prefetching DMA Read FIFO

This block streams a contiguous memory region into a byte FIFO. Once a fill is started with a base address and a byte length, it sends read requests to a memory port ahead of the consumer. Each request carries a slot tag. Responses may come back in any order, each one carrying the full data of its request in a single beat. The block still writes the returned bytes into the FIFO in the order the requests were issued. A consumer pops fixed-size chunks from the FIFO. Each pop either succeeds or is refused when too few bytes are buffered.

Issue is throttled by two limits together. One is the number of request slots. The other is the FIFO space still free once the bytes already buffered and the bytes still in flight are counted. A fill can be stopped at any time. Stopping halts issue at once, and data of requests still in flight is thrown away when it returns. Two levels report progress: end-of-block means the last request of the region has gone out, and idle means nothing is in flight. Each level has a one-cycle event pulse.

Top module: `dmaf_prefetch_fifo`

## Requirements
- R1: A request carries the current fill address and a size of min(REQ_MAX, end address minus current address). Consecutive requests of one fill cover the region in ascending address order without gaps.
- R2: No more than SLOTS requests are outstanding at once. A request is issued only while a slot is free and the fill has not reached its end address.
- R3: A request is issued only when FIFO level plus bytes in flight plus the new request size is at most FIFO_BYTES. The FIFO level never exceeds FIFO_BYTES.
- R4: Response data enters the FIFO strictly in request issue order. A response for a younger request waits until every older request has returned and retired.
- R5: A stop pulse blocks all further requests of the current fill and raises end-of-block. Data of requests outstanding at the stop is discarded and never reaches the FIFO.
- R6: A pop with at least CHUNK bytes buffered succeeds. One cycle later `pop_ok_o` pulses and `pop_data_o` holds the oldest CHUNK bytes, with the oldest byte in bits [7:0].
- R7: A pop with fewer than CHUNK bytes buffered pulses `pop_fail_o` one cycle later and leaves the FIFO contents and level unchanged.
- R8: A start pulse is accepted only while end-of-block is high. A start at any other time is ignored, and the running fill continues at its own addresses.
- R9: `eob_o` is high when no request is left to issue. This includes the state after reset. `eob_evt_o` pulses once, in the cycle after the final request of a fill is issued. A stop does not pulse it.
- R10: `idle_o` is high when no request is outstanding, including after reset. `idle_evt_o` pulses for one cycle when the outstanding count falls to zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a fill (honoured only at end-of-block) |
| start_addr_i | input | ADDR_W | First byte address of the region |
| start_len_i | input | ADDR_W | Region length in bytes |
| stop_i | input | 1 | Stop the fill and cancel outstanding data |
| req_valid_o | output | 1 | A read request is issued this cycle |
| req_addr_o | output | ADDR_W | Request byte address |
| req_size_o | output | $clog2(REQ_MAX+1) | Request size in bytes |
| req_tag_o | output | max(1,$clog2(SLOTS)) | Slot tag echoed on the response |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_tag_i | input | max(1,$clog2(SLOTS)) | Tag of the request being answered |
| rsp_data_i | input | REQ_MAX*8 | Response bytes, lowest address in bits [7:0] |
| pop_i | input | 1 | Consumer requests one chunk |
| pop_ok_o | output | 1 | Previous pop succeeded |
| pop_fail_o | output | 1 | Previous pop refused (underrun) |
| pop_data_o | output | CHUNK*8 | Chunk delivered by a successful pop |
| level_o | output | $clog2(FIFO_BYTES+1) | Bytes held in the FIFO |
| eob_o | output | 1 | Last request of the fill issued |
| eob_evt_o | output | 1 | One-cycle pulse on reaching end-of-block by issue |
| idle_o | output | 1 | No request outstanding |
| idle_evt_o | output | 1 | One-cycle pulse when the outstanding count reaches zero |

## Verification
The bench runs a region long enough to reach both throttles. It checks that issue stalls first on slots and later on FIFO space with all slots free. A design that tested only one of the limits would keep issuing past the point where the FIFO could hold the data. Answering a younger request before an older one exposes a design that retires by arrival: the FIFO level would rise early and the byte stream would come out scrambled. A stop followed by a new start while the cancelled slots are still outstanding exposes two faults. A design that forgot cancellation would let stale bytes into the new stream. A design that freed slots early would issue the new fill before the old responses arrived. A short tail request, an odd-length leftover and a pop against that leftover cover the sizing rule and the rule that a refused pop changes nothing.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

   // Width helper: at least one bit even for a single-entry structure.
   function automatic int clog2_min1(input int v);
      return (v <= 2) ? 1 : $clog2(v);
   endfunction

   // Ring index advance for a ring of arbitrary (not only power-of-two) size.
   function automatic int ring_next(input int idx, input int size);
      return (idx == size - 1) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/dmaf_bytefifo.sv
module dmaf_bytefifo
   import dmaf_pkg::*;
#(
   parameter  int DEPTH  = 32,
   parameter  int WR_MAX = 4,
   parameter  int RD_N   = 2,
   localparam int LW     = $clog2(DEPTH + 1),
   localparam int PW     = clog2_min1(DEPTH),
   localparam int SW     = $clog2(WR_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SW-1:0]       wr_len,
   input  logic [WR_MAX*8-1:0] wr_data,
   input  logic                rd_req,
   output logic                rd_ok_o,
   output logic                rd_fail_o,
   output logic [RD_N*8-1:0]   rd_data_o,
   output logic [LW-1:0]       level_o
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [PW-1:0] wr_idx [WR_MAX];
   logic [PW-1:0] rd_idx [RD_N];
   logic [LW-1:0] level_q;
   logic          can_rd;

   assign can_rd  = level_q >= LW'(RD_N);
   assign level_o = level_q;

   // Pointer arithmetic: natural wrap for power-of-two depth, modulo otherwise.
   if (POW2) begin : g_pow2
      for (genvar i = 0; i < WR_MAX; i++) begin : g_w
         assign wr_idx[i] = wp_q + PW'(i);
      end
      for (genvar i = 0; i < RD_N; i++) begin : g_r
         assign rd_idx[i] = rp_q + PW'(i);
      end
      assign wp_nx = wp_q + PW'(wr_len);
      assign rp_nx = rp_q + PW'(RD_N);
   end else begin : g_mod
      for (genvar i = 0; i < WR_MAX; i++) begin : g_w
         assign wr_idx[i] = PW'((32'(wp_q) + i) % DEPTH);
      end
      for (genvar i = 0; i < RD_N; i++) begin : g_r
         assign rd_idx[i] = PW'((32'(rp_q) + i) % DEPTH);
      end
      assign wp_nx = PW'((32'(wp_q) + 32'(wr_len)) % DEPTH);
      assign rp_nx = PW'((32'(rp_q) + 32'(RD_N)) % DEPTH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q      <= '0;
         rp_q      <= '0;
         level_q   <= '0;
         rd_ok_o   <= 1'b0;
         rd_fail_o <= 1'b0;
         rd_data_o <= '0;
      end else begin
         rd_ok_o   <= rd_req & can_rd;
         rd_fail_o <= rd_req & ~can_rd;
         if (rd_req && can_rd) begin
            for (int i = 0; i < RD_N; i++) rd_data_o[8*i +: 8] <= mem[rd_idx[i]];
            rp_q <= rp_nx;
         end
         if (wr_en) begin
            for (int i = 0; i < WR_MAX; i++)
               if (i < int'(wr_len)) mem[wr_idx[i]] <= wr_data[8*i +: 8];
            wp_q <= wp_nx;
         end
         level_q <= level_q + (wr_en ? LW'(wr_len) : LW'(0))
                            - ((rd_req && can_rd) ? LW'(RD_N) : LW'(0));
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(level_q) + 32'(wr_len) <= 32'(DEPTH)));

   assert_underrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fail_o |-> (32'(level_q) == 32'($past(level_q)) + ($past(wr_en) ? 32'($past(wr_len)) : 32'd0)));

endmodule

// File: rtl/dmaf_slots.sv
module dmaf_slots
   import dmaf_pkg::*;
#(
   parameter  int SLOTS  = 4,
   parameter  int REQ_MAX = 4,
   localparam int TW     = clog2_min1(SLOTS),
   localparam int SW     = $clog2(REQ_MAX + 1),
   localparam int CW     = $clog2(SLOTS + 1),
   localparam int BW     = $clog2(SLOTS * REQ_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc_i,
   input  logic [SW-1:0]        alloc_size_i,
   output logic [TW-1:0]        alloc_tag_o,
   output logic                 full_o,
   output logic                 empty_o,
   output logic [BW-1:0]        pend_bytes_o,
   input  logic                 rsp_valid_i,
   input  logic [TW-1:0]        rsp_tag_i,
   input  logic [REQ_MAX*8-1:0] rsp_data_i,
   input  logic                 cancel_all_i,
   output logic                 ret_o,
   output logic                 ret_keep_o,
   output logic [SW-1:0]        ret_size_o,
   output logic [REQ_MAX*8-1:0] ret_data_o
);

   logic [SLOTS-1:0]     vld_q, done_q, cncl_q;
   logic [SW-1:0]        size_q [SLOTS];
   logic [REQ_MAX*8-1:0] data_q [SLOTS];
   logic [TW-1:0]        head_q, tail_q;
   logic [CW-1:0]        cnt_q;
   logic [BW-1:0]        pend_q;

   assign alloc_tag_o  = tail_q;
   assign full_o       = cnt_q == CW'(SLOTS);
   assign empty_o      = cnt_q == '0;
   assign pend_bytes_o = pend_q;

   // Only the oldest slot may retire; younger finished slots wait for it.
   assign ret_o      = vld_q[head_q] & done_q[head_q];
   assign ret_keep_o = ~cncl_q[head_q] & ~cancel_all_i;
   assign ret_size_o = size_q[head_q];
   assign ret_data_o = data_q[head_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         done_q <= '0;
         cncl_q <= '0;
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
         pend_q <= '0;
         for (int s = 0; s < SLOTS; s++) begin
            size_q[s] <= '0;
            data_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < SLOTS; s++) begin
            if (alloc_i && tail_q == TW'(s)) begin
               vld_q[s]  <= 1'b1;
               done_q[s] <= 1'b0;
               cncl_q[s] <= 1'b0;
               size_q[s] <= alloc_size_i;
            end else begin
               if (ret_o && head_q == TW'(s)) vld_q[s] <= 1'b0;
               if (rsp_valid_i && rsp_tag_i == TW'(s)) begin
                  done_q[s] <= 1'b1;
                  data_q[s] <= rsp_data_i;
               end
               if (cancel_all_i) cncl_q[s] <= 1'b1;
            end
         end
         if (alloc_i) tail_q <= TW'(ring_next(int'(tail_q), SLOTS));
         if (ret_o)   head_q <= TW'(ring_next(int'(head_q), SLOTS));
         cnt_q  <= cnt_q + (alloc_i ? CW'(1) : CW'(0)) - (ret_o ? CW'(1) : CW'(0));
         pend_q <= pend_q + (alloc_i ? BW'(alloc_size_i) : BW'(0))
                          - (ret_o ? BW'(size_q[head_q]) : BW'(0));
      end
   end

   assert_slot_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> (cnt_q < CW'(SLOTS)));

   assert_rsp_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_i |-> (vld_q[rsp_tag_i] && !done_q[rsp_tag_i]));

endmodule

// File: rtl/dmaf_issue.sv
module dmaf_issue
   import dmaf_pkg::*;
#(
   parameter  int ADDR_W  = 16,
   parameter  int REQ_MAX = 4,
   parameter  int DEPTH   = 32,
   parameter  int LW      = 6,
   parameter  int BW      = 5,
   localparam int SW      = $clog2(REQ_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [ADDR_W-1:0] start_len_i,
   input  logic              stop_i,
   input  logic              slot_full_i,
   input  logic [LW-1:0]     level_i,
   input  logic [BW-1:0]     pend_i,
   output logic              issue_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [SW-1:0]     size_o,
   output logic              eob_o,
   output logic              eob_evt_o
);

   logic [ADDR_W-1:0] next_q, end_q, rem;
   logic              fits;

   assign rem    = end_q - next_q;
   assign size_o = (rem < ADDR_W'(REQ_MAX)) ? SW'(rem) : SW'(REQ_MAX);
   assign addr_o = next_q;
   assign eob_o  = next_q == end_q;
   // Space test counts buffered bytes, bytes still in flight and the new request.
   assign fits   = (32'(level_i) + 32'(pend_i) + 32'(size_o)) <= 32'(DEPTH);
   assign issue_o = ~eob_o & ~slot_full_i & ~stop_i & fits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_q    <= '0;
         end_q     <= '0;
         eob_evt_o <= 1'b0;
      end else begin
         eob_evt_o <= issue_o && (ADDR_W'(size_o) == rem);
         if (stop_i)                 next_q <= end_q;
         else if (start_i && eob_o) begin
            next_q <= start_addr_i;
            end_q  <= start_addr_i + start_len_i;
         end else if (issue_o)       next_q <= next_q + ADDR_W'(size_o);
      end
   end

   assert_req_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
      issue_o |-> (size_o != '0 && 32'(size_o) <= 32'(REQ_MAX)));

   assert_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (eob_o && !issue_o));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !eob_o && !stop_i) |=> $stable(end_q));

   assert_eob_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eob_evt_o |-> eob_o);

endmodule

// File: rtl/dmaf_prefetch_fifo.sv
module dmaf_prefetch_fifo
   import dmaf_pkg::*;
#(
   parameter  int ADDR_W     = 16,
   parameter  int FIFO_BYTES = 32,
   parameter  int REQ_MAX    = 4,
   parameter  int SLOTS      = 4,
   parameter  int CHUNK      = 2,
   localparam int SW         = $clog2(REQ_MAX + 1),
   localparam int TW         = clog2_min1(SLOTS),
   localparam int LW         = $clog2(FIFO_BYTES + 1),
   localparam int BW         = $clog2(SLOTS * REQ_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [ADDR_W-1:0]    start_addr_i,
   input  logic [ADDR_W-1:0]    start_len_i,
   input  logic                 stop_i,
   output logic                 req_valid_o,
   output logic [ADDR_W-1:0]    req_addr_o,
   output logic [SW-1:0]        req_size_o,
   output logic [TW-1:0]        req_tag_o,
   input  logic                 rsp_valid_i,
   input  logic [TW-1:0]        rsp_tag_i,
   input  logic [REQ_MAX*8-1:0] rsp_data_i,
   input  logic                 pop_i,
   output logic                 pop_ok_o,
   output logic                 pop_fail_o,
   output logic [CHUNK*8-1:0]   pop_data_o,
   output logic [LW-1:0]        level_o,
   output logic                 eob_o,
   output logic                 eob_evt_o,
   output logic                 idle_o,
   output logic                 idle_evt_o
);

   if (REQ_MAX < 1 || REQ_MAX > FIFO_BYTES) begin : g_bad_req
      $error("REQ_MAX must lie in 1..FIFO_BYTES");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (CHUNK < 1 || CHUNK > FIFO_BYTES || FIFO_BYTES < 2) begin : g_bad_chunk
      $error("CHUNK must lie in 1..FIFO_BYTES and FIFO_BYTES must be at least 2");
   end

   logic                 slot_full, slot_empty, ret, ret_keep, idle_prev_q;
   logic [BW-1:0]        pend_bytes;
   logic [SW-1:0]        ret_size;
   logic [REQ_MAX*8-1:0] ret_data;

   dmaf_issue #(
      .ADDR_W(ADDR_W), .REQ_MAX(REQ_MAX), .DEPTH(FIFO_BYTES), .LW(LW), .BW(BW)
   ) u_issue (
      .clk, .rst_n, .start_i, .start_addr_i, .start_len_i, .stop_i,
      .slot_full_i(slot_full), .level_i(level_o), .pend_i(pend_bytes),
      .issue_o(req_valid_o), .addr_o(req_addr_o), .size_o(req_size_o),
      .eob_o, .eob_evt_o
   );

   dmaf_slots #(.SLOTS(SLOTS), .REQ_MAX(REQ_MAX)) u_slots (
      .clk, .rst_n,
      .alloc_i(req_valid_o), .alloc_size_i(req_size_o), .alloc_tag_o(req_tag_o),
      .full_o(slot_full), .empty_o(slot_empty), .pend_bytes_o(pend_bytes),
      .rsp_valid_i, .rsp_tag_i, .rsp_data_i, .cancel_all_i(stop_i),
      .ret_o(ret), .ret_keep_o(ret_keep), .ret_size_o(ret_size), .ret_data_o(ret_data)
   );

   dmaf_bytefifo #(.DEPTH(FIFO_BYTES), .WR_MAX(REQ_MAX), .RD_N(CHUNK)) u_fifo (
      .clk, .rst_n,
      .wr_en(ret & ret_keep), .wr_len(ret_size), .wr_data(ret_data),
      .rd_req(pop_i), .rd_ok_o(pop_ok_o), .rd_fail_o(pop_fail_o),
      .rd_data_o(pop_data_o), .level_o
   );

   assign idle_o     = slot_empty;
   assign idle_evt_o = slot_empty & ~idle_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) idle_prev_q <= 1'b1;
      else        idle_prev_q <= slot_empty;
   end

   assert_capacity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(level_o) + 32'(pend_bytes)) <= 32'(FIFO_BYTES));

   assert_idle_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt_o |-> (idle_o && !$past(idle_o)));

endmodule

// File: tb/sim_dmaf_prefetch_fifo.sv
module sim_dmaf_prefetch_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16, FB = 32, RM = 4, NS = 4, CK = 2;
   localparam int SW = $clog2(RM + 1), TW = 2, LW = $clog2(FB + 1);

   logic clk = 0, rst_n = 0;
   logic start_i = 0, stop_i = 0, rsp_valid_i = 0, pop_i = 0;
   logic [AW-1:0] start_addr_i = '0, start_len_i = '0;
   logic [TW-1:0] rsp_tag_i = '0;
   logic [RM*8-1:0] rsp_data_i = '0;
   logic req_valid_o, pop_ok_o, pop_fail_o, eob_o, eob_evt_o, idle_o, idle_evt_o;
   logic [AW-1:0] req_addr_o;
   logic [SW-1:0] req_size_o;
   logic [TW-1:0] req_tag_o;
   logic [CK*8-1:0] pop_data_o;
   logic [LW-1:0] level_o;

   dmaf_prefetch_fifo #(.ADDR_W(AW), .FIFO_BYTES(FB), .REQ_MAX(RM), .SLOTS(NS), .CHUNK(CK)) u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, n_req = 0, n_eob = 0, n_idle = 0, q_n = 0;
   int q_tag [16], q_addr [16], q_size [16];
   int exp_b [128];
   int exp_h = 0, exp_t = 0;

   function automatic int mb(input int a);
      return (a & 8'hFF) ^ (((a >> 8) & 4'hF) * 8'h11);
   endfunction

   task automatic chk(input string r, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
      end
   endtask

   // Memory-side monitor: records issued requests and event pulses.
   always @(negedge clk) begin
      #1;
      if (rst_n && req_valid_o) begin
         q_tag[q_n] = int'(req_tag_o); q_addr[q_n] = int'(req_addr_o);
         q_size[q_n] = int'(req_size_o); q_n++; n_req++;
      end
      if (rst_n && eob_evt_o)  n_eob++;
      if (rst_n && idle_evt_o) n_idle++;
   end

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_range(input int a, input int n);
      for (int i = 0; i < n; i++) begin exp_b[exp_t] = mb(a + i); exp_t++; end
   endtask

   task automatic start_fill(input int a, input int l);
      @(negedge clk); start_i = 1; start_addr_i = AW'(a); start_len_i = AW'(l);
      @(negedge clk); start_i = 0;
   endtask

   task automatic stop_fill();
      @(negedge clk); stop_i = 1;
      @(negedge clk); stop_i = 0;
   endtask

   task automatic respond(input int k);
      @(negedge clk);
      rsp_valid_i = 1; rsp_tag_i = TW'(q_tag[k]); rsp_data_i = '0;
      for (int i = 0; i < q_size[k]; i++) rsp_data_i[8*i +: 8] = 8'(mb(q_addr[k] + i));
      for (int j = k; j < q_n - 1; j++) begin
         q_tag[j] = q_tag[j+1]; q_addr[j] = q_addr[j+1]; q_size[j] = q_size[j+1];
      end
      q_n--;
      @(negedge clk); rsp_valid_i = 0;
   endtask

   task automatic pop_chk(input bit exp_ok, input string r);
      @(negedge clk); pop_i = 1;
      @(negedge clk); pop_i = 0;
      #1;
      chk({r, " pop_ok"}, int'(pop_ok_o), int'(exp_ok));
      chk({r, " pop_fail"}, int'(pop_fail_o), int'(!exp_ok));
      if (exp_ok) begin
         for (int i = 0; i < CK; i++) begin
            chk({r, " pop byte"}, int'(pop_data_o[8*i +: 8]), exp_b[exp_h]);
            exp_h++;
         end
      end
   endtask

   task automatic t_reset();
      #1;
      chk("R9 eob after reset", int'(eob_o), 1);
      chk("R10 idle after reset", int'(idle_o), 1);
      chk("R3 level after reset", int'(level_o), 0);
      chk("R2 no request after reset", int'(req_valid_o), 0);
      pop_chk(0, "R7 empty underrun");
   endtask

   task automatic t_throttle();
      n_eob = 0; n_req = 0;
      expect_range(16'h100, 38);
      start_fill(16'h100, 38);
      waitc(8);
      chk("R2 slot limit count", n_req, NS);
      for (int k = 0; k < NS; k++) begin
         chk("R1 size", q_size[k], RM);
         chk("R1 addr", q_addr[k], 16'h100 + 4 * k);
      end
      chk("R9 eob low mid fill", int'(eob_o), 0);
      start_fill(16'h700, 4);             // not at end-of-block: must be ignored (R8)
      waitc(3);
      chk("R8 ignored start issues nothing", n_req, NS);
      for (int k = 0; k < NS; k++) respond(0);
      waitc(8);
      chk("R3 count at space limit", n_req, 8);
      chk("R8 fill continues at own address", q_addr[0], 16'h110);
      chk("R4 level after in-order retire", int'(level_o), 16);
      for (int k = 0; k < NS; k++) respond(0);
      waitc(6);
      chk("R4 level full", int'(level_o), 32);
      chk("R3 no issue with free slots and full FIFO", n_req, 8);
      chk("R10 idle when nothing outstanding", int'(idle_o), 1);
      pop_chk(1, "R6 first pop");
      waitc(4);
      chk("R3 still blocked at level 30", n_req, 8);
      pop_chk(1, "R6 second pop");
      waitc(4);
      chk("R3 issue once space frees", n_req, 9);
      chk("R1 addr after space frees", q_addr[0], 16'h120);
      pop_chk(1, "R6 third pop");
      waitc(4);
      chk("R1 tail count", n_req, 10);
      chk("R1 short tail size", q_size[1], 2);
      chk("R1 tail addr", q_addr[1], 16'h124);
      chk("R9 eob level at end", int'(eob_o), 1);
      chk("R9 single eob pulse", n_eob, 1);
      respond(0); respond(0);
      waitc(4);
      chk("R3 level after tail", int'(level_o), 32);
      for (int k = 0; k < 16; k++) pop_chk(1, "R6 drain");
      pop_chk(0, "R7 drained underrun");
      chk("R7 level zero", int'(level_o), 0);
   endtask

   task automatic t_reorder();
      n_eob = 0; n_idle = 0; n_req = 0;
      expect_range(16'h200, 5);
      start_fill(16'h200, 5);
      waitc(5);
      chk("R1 two requests", n_req, 2);
      chk("R1 second size", q_size[1], 1);
      respond(1);                          // younger answers first
      waitc(4);
      chk("R4 younger held back", int'(level_o), 0);
      chk("R10 not idle with one outstanding", int'(idle_o), 0);
      respond(0);
      waitc(4);
      chk("R4 both retired", int'(level_o), 5);
      chk("R9 eob pulse count", n_eob, 1);
      chk("R10 idle pulse count", n_idle, 1);
      pop_chk(1, "R4 ordered bytes");
      pop_chk(1, "R4 ordered bytes");
      pop_chk(0, "R7 partial underrun");
      chk("R7 level kept", int'(level_o), 1);
   endtask

   task automatic t_stop();
      n_eob = 0; n_req = 0;
      start_fill(16'h300, 40);
      waitc(8);
      chk("R2 outstanding before stop", n_req, NS);
      stop_fill();
      waitc(4);
      chk("R5 no request after stop", n_req, NS);
      chk("R5 eob after stop", int'(eob_o), 1);
      chk("R9 stop gives no eob pulse", n_eob, 0);
      expect_range(16'h400, 3);
      start_fill(16'h400, 3);
      waitc(3);
      chk("R2 new fill waits for slots", n_req, NS);
      for (int k = 0; k < NS; k++) respond(0);
      waitc(4);
      chk("R5 cancelled data dropped", int'(level_o), 1);
      chk("R2 new fill issues after slots free", n_req, NS + 1);
      chk("R1 new fill addr", q_addr[0], 16'h400);
      respond(0);
      waitc(4);
      chk("R5 new data kept", int'(level_o), 4);
      pop_chk(1, "R6 leftover then new");
      pop_chk(1, "R6 new fill bytes");
      pop_chk(0, "R7 empty after stop test");
      chk("R10 idle at end", int'(idle_o), 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      waitc(3);
      rst_n = 1;
      t_reset();
      t_throttle();
      t_reorder();
      t_stop();
      waitc(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule